// File: doc/BRIEF.md
# Receive DMA Burst Scheduler

This block decides when the receive DMA engine may begin writing a burst of frame data to host memory, and how many bytes that burst carries. Each cycle it compares the receive FIFO fill level against a programmable burst size. A burst is also released early once the end of a frame is already held in the FIFO. A burst is released only when one of these conditions holds and no earlier burst is still outstanding.

Full bursts are shortened when needed so that the following burst begins on a cacheline boundary of host memory. Bursts shorter than a cacheline and end-of-frame bursts are never shortened. Separately, the block raises a registered high-priority flag toward the transmit/receive DMA arbiter whenever the FIFO holds more data than a programmable threshold. Two small configuration fields, the burst size and the priority threshold, are held inside the block and loaded through a write strobe.

Top module: `rx_burst_sched`

## Requirements
- R1: After reset, burst_start and high_prio are 0, the burst size field is 4 (128 bytes) and the threshold field is 6 (1536 bytes).
- R2: When cfg_we is 1 at a clock edge, the burst size field takes cfg_burst_units and the threshold field takes cfg_prio_level; the new values govern decisions from the next cycle on.
- R3: The programmed burst length P is the burst size field times 32 bytes, with a field of 0 treated as 1. A burst is issued at a clock edge only when no burst is outstanding and either fifo_bytes >= P or (eof_stored is 1 and eof_bytes is nonzero); burst_start is 1 in the cycle that follows.
- R4: A burst issued without a usable end of frame, with P at least LINE_BYTES and host_addr + P not a multiple of LINE_BYTES, has burst_bytes = P - ((host_addr + P) mod LINE_BYTES), so it ends on a cacheline boundary.
- R5: A burst issued without a usable end of frame and with P below LINE_BYTES has burst_bytes = P whatever the address.
- R6: A burst issued while eof_stored is 1 and eof_bytes is nonzero has burst_bytes = min(eof_bytes, P) and is never shortened for alignment.
- R7: burst_start is high for exactly one cycle per burst; after it, no further burst starts until burst_done has been 1 at some edge (burst_done in the cycle of burst_start counts); burst_done while nothing is outstanding has no effect.
- R8: high_prio equals (fifo_bytes > threshold field × 256) as sampled at the previous clock edge.
- R9: burst_bytes keeps its value from one burst_start until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load both configuration fields |
| cfg_burst_units | input | 7 | New burst size, in 32-byte units |
| cfg_prio_level | input | 4 | New priority threshold, in 256-byte units |
| fifo_bytes | input | CNT_W | Bytes currently held in the receive FIFO |
| eof_stored | input | 1 | An end of frame is held in the FIFO |
| eof_bytes | input | CNT_W | Bytes held up to and including that end of frame |
| host_addr | input | ADDR_W | Host address where the next burst will be written |
| burst_done | input | 1 | The outstanding burst has completed |
| burst_start | output | 1 | One-cycle pulse: a burst is granted |
| burst_bytes | output | 12 | Byte count of the granted burst |
| high_prio | output | 1 | Raise receive DMA priority at the arbiter |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it: burst_start, burst_bytes and high_prio are registers loaded from the values present at that edge, and configuration writes alter decisions from the edge after the write. The bench drives each cycle's inputs at the falling edge, advances its own model of the outstanding burst and the configuration fields, and compares the outputs at the next falling edge, one rising edge later. Directed cases cover the reset defaults, the exact fill-level and priority boundaries, aligned and misaligned addresses, short bursts and end-of-frame bursts before the random phase.

// File: rtl/rx_burst_sched.sv
module rx_burst_sched #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [6:0]        cfg_burst_units,
  input  logic [3:0]        cfg_prio_level,
  input  logic [CNT_W-1:0]  fifo_bytes,
  input  logic              eof_stored,
  input  logic [CNT_W-1:0]  eof_bytes,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              burst_done,
  output logic              burst_start,
  output logic [11:0]       burst_bytes,
  output logic              high_prio
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);

  logic [6:0] burst_q;
  logic [3:0] thr_q;
  logic       busy_q;

  wire  [6:0]       units  = (burst_q == 7'd0) ? 7'd1 : burst_q;
  wire  [11:0]      prog   = {units, 5'b00000};
  wire  [CNT_W-1:0] prog_w = CNT_W'(prog);

  wire full_ok = fifo_bytes >= prog_w;
  wire eof_ok  = eof_stored && (eof_bytes != '0);
  wire go      = !busy_q && (full_ok || eof_ok);

  wire [LINE_LSB-1:0] end_lo  = host_addr[LINE_LSB-1:0] + prog[LINE_LSB-1:0];
  wire                long_b  = prog >= 12'(LINE_BYTES);
  wire [11:0]         trim_b  = prog - 12'(end_lo);
  wire [11:0]         eof_len = (eof_bytes < prog_w) ? eof_bytes[11:0] : prog;

  wire [11:0] len_next = eof_ok                        ? eof_len :
                         (long_b && end_lo != '0)       ? trim_b  : prog;

  wire prio_next = fifo_bytes > CNT_W'({thr_q, 8'h00});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 7'd4;
      thr_q   <= 4'd6;
    end else if (cfg_we) begin
      burst_q <= cfg_burst_units;
      thr_q   <= cfg_prio_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      burst_start <= 1'b0;
      burst_bytes <= '0;
      high_prio   <= 1'b0;
    end else begin
      burst_start <= go;
      high_prio   <= prio_next;
      if (go) begin
        busy_q      <= 1'b1;
        burst_bytes <= len_next;
      end else if (burst_done) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

module rx_burst_sched_chk #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  fifo_bytes,
  input logic              eof_stored,
  input logic [CNT_W-1:0]  eof_bytes,
  input logic [ADDR_W-1:0] host_addr,
  input logic              burst_done,
  input logic              burst_start,
  input logic [11:0]       burst_bytes,
  input logic              high_prio,
  input logic [3:0]        thr_q
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);

  logic outst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= 1'b0;
    else        outst <= (outst || burst_start) && !burst_done;
  end

  wire eof_use = eof_stored && (eof_bytes != '0);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!burst_start && !high_prio));

  assert_fill_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && !$past(eof_use)) |-> ($past(fifo_bytes) >= CNT_W'(burst_bytes) && burst_bytes != '0));

  assert_line_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && !$past(eof_use) && burst_bytes >= 12'(LINE_BYTES))
      |-> (($past(host_addr[LINE_LSB-1:0]) + burst_bytes[LINE_LSB-1:0]) == '0));

  assert_eof_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && $past(eof_use)) |-> (CNT_W'(burst_bytes) <= $past(eof_bytes) && burst_bytes != '0));

  assert_one_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> !burst_start);

  assert_wait_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> !outst);

  assert_prio_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (high_prio == ($past(fifo_bytes) > CNT_W'({$past(thr_q), 8'h00}))));

  assert_len_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_start |-> $stable(burst_bytes));
endmodule

bind rx_burst_sched rx_burst_sched_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_bytes(fifo_bytes), .eof_stored(eof_stored),
  .eof_bytes(eof_bytes), .host_addr(host_addr), .burst_done(burst_done),
  .burst_start(burst_start), .burst_bytes(burst_bytes), .high_prio(high_prio),
  .thr_q(thr_q)
);

// File: tb/sim_rx_burst_sched.sv
module sim_rx_burst_sched;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int LINE   = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [6:0]        cfg_burst_units = '0;
  logic [3:0]        cfg_prio_level = '0;
  logic [CNT_W-1:0]  fifo_bytes = '0;
  logic              eof_stored = 1'b0;
  logic [CNT_W-1:0]  eof_bytes = '0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic              burst_done = 1'b0;
  logic              burst_start;
  logic [11:0]       burst_bytes;
  logic              high_prio;

  rx_burst_sched #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_BYTES(LINE)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_burst_units(cfg_burst_units),
    .cfg_prio_level(cfg_prio_level), .fifo_bytes(fifo_bytes), .eof_stored(eof_stored),
    .eof_bytes(eof_bytes), .host_addr(host_addr), .burst_done(burst_done),
    .burst_start(burst_start), .burst_bytes(burst_bytes), .high_prio(high_prio));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit m_busy = 0;
  int m_units = 4;
  int m_thr = 6;
  int last_len = 0;

  function automatic int prog_len(int u);
    return (u == 0) ? 32 : u * 32;
  endfunction

  function automatic int exp_len(longint addr, int p, bit eof_use, int eb);
    longint line_end;
    if (eof_use) return (eb < p) ? eb : p;
    if (p < LINE) return p;
    line_end = ((addr + p) / LINE) * LINE;
    return int'(line_end - addr);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(int fifo, bit eof, int eb, longint addr, bit done,
                     bit we, int bu, int th, string tag);
    int p; bit eof_use; bit go; bit prio; int len; string st; string lt;
    fifo_bytes = CNT_W'(fifo); eof_stored = eof; eof_bytes = CNT_W'(eb);
    host_addr = ADDR_W'(addr); burst_done = done;
    cfg_we = we; cfg_burst_units = 7'(bu); cfg_prio_level = 4'(th);
    p = prog_len(m_units);
    eof_use = eof && (eb != 0);
    go = !m_busy && (fifo >= p || eof_use);
    prio = fifo > m_thr * 256;
    len = exp_len(addr, p, eof_use, eb);
    st = (tag != "") ? tag : (m_busy ? "R7" : "R3");
    lt = (tag != "") ? tag : (eof_use ? "R6" : (p < LINE ? "R5" : "R4"));
    if (go) begin m_busy = 1; last_len = len; end
    else if (done) m_busy = 0;
    if (we) begin m_units = bu; m_thr = th; end
    @(posedge clk);
    @(negedge clk);
    check(st, int'(burst_start), int'(go));
    if (go) check(lt, int'(burst_bytes), len);
    else    check("R9", int'(burst_bytes), last_len);
    check((tag != "") ? tag : "R8", int'(high_prio), int'(prio));
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    check("R1", int'(burst_start), 0);
    check("R1", int'(high_prio), 0);
    rst_n = 1'b1;
    // R1: default 128-byte burst and 1536-byte threshold
    cyc(127, 0, 0, 0, 0, 0, 0, 0, "R1");
    cyc(1536, 0, 0, 0, 0, 0, 0, 0, "R1");
    cyc(1537, 0, 0, 0, 1, 0, 0, 0, "R1");
    cyc(128, 0, 0, 0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "");
    // R2: reconfigure to 96-byte bursts, threshold 256
    cyc(0, 0, 0, 0, 0, 1, 3, 1, "R2");
    cyc(257, 0, 0, 32'h20, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "");
    // R4: misaligned full burst is trimmed to 88 bytes
    cyc(96, 0, 0, 32'h28, 0, 0, 0, 0, "R4");
    // R7: held high fill level, no done: no new start
    cyc(500, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(500, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(500, 0, 0, 0, 1, 0, 0, 0, "R7");
    cyc(95, 0, 0, 0, 1, 0, 0, 0, "R7");
    cyc(95, 0, 0, 0, 1, 0, 0, 0, "R3");
    // R5: 32-byte bursts are never trimmed
    cyc(0, 0, 0, 0, 0, 1, 1, 15, "R2");
    cyc(40, 0, 0, 32'h30, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "");
    // R3: size field 0 acts as 32 bytes
    cyc(0, 0, 0, 0, 0, 1, 0, 6, "R2");
    cyc(31, 0, 0, 0, 0, 0, 0, 0, "R3");
    cyc(32, 0, 0, 32'h4, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "");
    // R6: end-of-frame bursts, short and long
    cyc(0, 0, 0, 0, 0, 1, 3, 6, "R2");
    cyc(20, 1, 20, 32'h28, 0, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "");
    cyc(400, 1, 300, 32'h28, 0, 0, 0, 0, "R6");
    cyc(10, 1, 0, 0, 1, 0, 0, 0, "R6");
    cyc(10, 1, 0, 0, 0, 0, 0, 0, "R3");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int f; bit e; int eb; longint a; bit d; bit w;
      f  = int'($urandom_range(0, 4095));
      e  = ($urandom_range(0, 4) == 0);
      eb = e ? int'($urandom_range(0, f)) : 0;
      a  = longint'({$urandom(), 2'b00} & 32'hFFFF_FFFC);
      d  = m_busy ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 5) == 0);
      w  = ($urandom_range(0, 19) == 0);
      cyc(f, e, eb, a, d, w, int'($urandom_range(0, 127)), int'($urandom_range(0, 15)), "");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule